// File: doc/BRIEF.md
# Rotating Ring Frequency Divider

This block divides its clock with a circular shift register of 2·HALF flops. Synchronous reset loads the low HALF stages with zeros and the high HALF stages with ones. Each enabled clock moves every bit up one stage, and the top stage wraps into stage 0. The pattern therefore circulates with no counter and no compare logic. The top stage is the square output: it comes straight from a flop, so it has exactly 50% duty and cannot glitch.

The low HALF stages are exposed as a tap vector. A registered adder counts the ones among them. As the pattern rotates, this level climbs from 0 to HALF and falls back by one step per clock, which gives a digital staircase in place of a resistor summing network.

STAGES copies of the ring are chained. Each later ring is stepped by a small two-state edge tracker that watches the square output of the ring before it. The tracker sits in ST_SEEN_HIGH after reset. It moves to ST_SEEN_LOW when the watched square is low on an enabled clock. From ST_SEEN_LOW it returns to ST_SEEN_HIGH on the first enabled clock with the square high, and on that clock it emits one step. The tracker changes state only on enabled clocks.

Top module: `ring_divider`

## Requirements
- R1: While reset is sampled high, every bit of sq_o becomes 1, every bit of taps_o becomes 0 and every field of level_o becomes 0 at the following edge.
- R2: With en held high, sq_o[0] has a period of 2·HALF clocks, high for HALF clocks and low for HALF clocks. It changes only on an edge where en was high.
- R3: For ring k, taps_o[k*HALF +: HALF] shows stages 0..HALF-1. On each step the field shifts toward its MSB and the previous sq_o[k] (stage 2·HALF-1) enters bit 0.
- R4: level_o[k*LW +: LW] after an edge equals the number of ones in ring k's tap field before that edge.
- R5: Outside reset, level stays within 0..HALF and differs by at most 1 between consecutive clocks.
- R6: With en held high, every window of 2·HALF consecutive clocks contains exactly one clock with level 0 and exactly one with level HALF.
- R7: A clock with en low leaves sq_o and taps_o unchanged.
- R8: Reset asserted during operation reloads the initial fill, even with en high.
- R9: Ring k+1 takes one step on the first enabled clock after sq_o[k] has risen. With en held high, sq_o[1] has a period of (2·HALF)² clocks and is high for 2·HALF·HALF of them.
- R10: A pending step for ring k+1 is kept through clocks with en low and is taken on the next clock with en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, reloads every ring |
| en | input | 1 | Clock enable; low freezes all rings |
| sq_o | output | STAGES | Square output of each ring (top stage flop) |
| taps_o | output | STAGES*HALF | Tap fields of all rings, ring k at k*HALF |
| level_o | output | STAGES*LW | Registered ones count per ring, LW = clog2(HALF+1) |

## Verification
The embedded properties compare values against the previous clock and are masked on the first clock after reset. They therefore assume that reset is held for at least two clocks at power-up and that en changes only between edges. The stimulus holds reset for three clocks and changes en and rst one nanosecond after each rising edge. It interleaves long runs with en held high, irregular en patterns, en held low just after a rise of the first square, and a reset applied while enabled.

// File: rtl/ring_div_pkg.sv
package ring_div_pkg;

    // Cascade edge tracker: has the watched square been seen low since the last step
    typedef enum logic {
        ST_SEEN_HIGH = 1'b0,
        ST_SEEN_LOW  = 1'b1
    } link_state_t;

    // Width able to hold a count 0..half
    function automatic int lvl_width(input int half);
        return $clog2(half + 1);
    endfunction

endpackage

// File: rtl/ring_shift.sv
module ring_shift #(
    parameter int HALF = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,
    output logic            sq_o,
    output logic [HALF-1:0] taps_o
);
    localparam int N = 2 * HALF;
    localparam logic [N-1:0] FILL = {{HALF{1'b1}}, {HALF{1'b0}}};

    logic [N-1:0] ring_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= FILL;
        end else if (adv_i) begin
            ring_q <= {ring_q[N-2:0], ring_q[N-1]};
        end
    end

    assign sq_o   = ring_q[N-1];
    assign taps_o = ring_q[HALF-1:0];

    // R3: rotation never creates or drops a one
    p_ones_conserved_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(ring_q) == HALF)
        else $error("ring lost its fill");

    // R7: a clock without a step leaves the ring untouched
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(ring_q))
        else $error("ring moved while frozen");

endmodule

// File: rtl/tap_sum.sv
module tap_sum #(
    parameter int HALF = 9,
    parameter int LW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HALF-1:0] taps_i,
    output logic [LW-1:0]   level_o
);
    logic [LW-1:0] cnt;
    logic [LW-1:0] level_q;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < HALF; i++) begin
            cnt = cnt + LW'(taps_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= cnt;
    end

    assign level_o = level_q;

    // R5: level stays within the tap count
    p_level_range_r5: assert property (@(posedge clk) disable iff (rst)
        level_q <= LW'(HALF))
        else $error("level above tap count");

    // R5: staircase moves by at most one per clock
    p_level_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((level_q >= $past(level_q)) ? (level_q - $past(level_q)) <= 1
                                                     : ($past(level_q) - level_q) <= 1))
        else $error("level jumped");

endmodule

// File: rtl/ring_edge_fsm.sv
module ring_edge_fsm
    import ring_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic sq_i,
    output logic adv_o
);
    link_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEEN_HIGH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (en_i) begin
            unique case (state_q)
                ST_SEEN_HIGH: if (!sq_i) state_d = ST_SEEN_LOW;
                ST_SEEN_LOW:  if (sq_i)  state_d = ST_SEEN_HIGH;
            endcase
        end
    end

    always_comb begin
        adv_o = 1'b0;
        unique case (state_q)
            ST_SEEN_HIGH: adv_o = 1'b0;
            ST_SEEN_LOW:  adv_o = en_i && sq_i;
        endcase
    end

    // R9: a step is issued only while the watched square is high
    p_step_on_high_r9: assert property (@(posedge clk) disable iff (rst)
        adv_o |-> sq_i)
        else $error("step without high square");

    // R9: one step per rise
    p_step_once_r9: assert property (@(posedge clk) disable iff (rst)
        adv_o |=> !adv_o)
        else $error("double step");

    // R10: a pending step survives a clock with enable low
    p_pending_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEEN_LOW && sq_i && !en_i) |=> (state_q == ST_SEEN_LOW))
        else $error("pending step lost");

endmodule

// File: rtl/ring_stage.sv
module ring_stage #(
    parameter int HALF = 9,
    parameter int LW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv_i,
    output logic            sq_o,
    output logic [HALF-1:0] taps_o,
    output logic [LW-1:0]   level_o
);
    logic [HALF-1:0] taps;

    ring_shift #(.HALF(HALF)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (adv_i),
        .sq_o   (sq_o),
        .taps_o (taps)
    );

    tap_sum #(.HALF(HALF), .LW(LW)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .taps_i  (taps),
        .level_o (level_o)
    );

    assign taps_o = taps;

endmodule

// File: rtl/ring_divider.sv
module ring_divider
    import ring_div_pkg::*;
#(
    parameter  int HALF   = 9,
    parameter  int STAGES = 2,
    localparam int LW     = lvl_width(HALF)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    output logic [STAGES-1:0]      sq_o,
    output logic [STAGES*HALF-1:0] taps_o,
    output logic [STAGES*LW-1:0]   level_o
);
    logic [STAGES-1:0] adv;

    assign adv[0] = en;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        ring_stage #(.HALF(HALF), .LW(LW)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .adv_i   (adv[s]),
            .sq_o    (sq_o[s]),
            .taps_o  (taps_o[s*HALF +: HALF]),
            .level_o (level_o[s*LW +: LW])
        );
        if (s > 0) begin : g_link
            ring_edge_fsm u_link (
                .clk   (clk),
                .rst   (rst),
                .en_i  (en),
                .sq_i  (sq_o[s-1]),
                .adv_o (adv[s])
            );
        end
    end

    // R2: first square only changes on an enabled edge
    p_sq_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sq_o[0] != $past(sq_o[0])) |-> $past(en))
        else $error("square moved without enable");

endmodule

// File: tb/tb_ring_divider.sv
module tb_ring_divider;
    localparam int H  = 9;
    localparam int S  = 2;
    localparam int N  = 2 * H;
    localparam int LW = $clog2(H + 1);
    localparam logic [N-1:0] FILL = {{H{1'b1}}, {H{1'b0}}};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [S-1:0]    sq;
    logic [S*H-1:0]  taps;
    logic [S*LW-1:0] lvl;

    ring_divider #(.HALF(H), .STAGES(S)) dut (
        .clk(clk), .rst(rst), .en(en), .sq_o(sq), .taps_o(taps), .level_o(lvl)
    );

    int checks = 0, fails = 0, ncyc = 0;
    bit done = 0;
    always @(posedge clk) ncyc <= ncyc + 1;

    typedef struct {
        int              cyc;
        logic [S-1:0]    sq;
        logic [S*H-1:0]  taps;
        logic [S*LW-1:0] lvl;
    } exp_t;
    exp_t sb[$];

    logic [N-1:0]  m1, m2;
    logic          m_low;
    logic [LW-1:0] ml1, ml2;

    function automatic logic [N-1:0] rot(input logic [N-1:0] v);
        return {v[N-2:0], v[N-1]};
    endfunction

    function automatic logic [LW-1:0] ones(input logic [H-1:0] v);
        logic [LW-1:0] c = '0;
        for (int i = 0; i < H; i++) c = c + LW'(v[i]);
        return c;
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: sets inputs, advances the model for the coming edge, queues the result
    task automatic drive(input logic r, input logic e);
        exp_t it;
        logic stp;
        rst = r;
        en  = e;
        if (r) begin
            m1 = FILL; m2 = FILL; m_low = 1'b0; ml1 = '0; ml2 = '0;
        end else begin
            ml1 = ones(m1[H-1:0]);
            ml2 = ones(m2[H-1:0]);
            if (e) begin
                stp   = m_low & m1[N-1];
                m_low = ~m1[N-1];
                m1    = rot(m1);
                if (stp) m2 = rot(m2);
            end
        end
        it.cyc  = ncyc + 1;
        it.sq   = {m2[N-1], m1[N-1]};
        it.taps = {m2[H-1:0], m1[H-1:0]};
        it.lvl  = {ml2, ml1};
        sb.push_back(it);
        @(posedge clk);
        #1;
    endtask

    // Monitor: pops expected items once their edge has passed
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].cyc <= ncyc) begin
            e = sb.pop_front();
            check_eq("R2 square ring0",  int'(sq[0]), int'(e.sq[0]));
            check_eq("R9 square ring1",  int'(sq[1]), int'(e.sq[1]));
            check_eq("R3 taps",          int'(taps),  int'(e.taps));
            check_eq("R4 levels",        int'(lvl),   int'(e.lvl));
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int last0, hi0, zc, hc, last1, hi1, l, pl;
        logic p0, p1;
        logic [H-1:0] t1;
        logic s1;
        @(posedge clk); #1;
        repeat (3) drive(1'b1, 1'b0);
        // R1 reset state
        check_eq("R1 squares", int'(sq), 3);
        check_eq("R1 taps", int'(taps), 0);
        check_eq("R1 levels", int'(lvl), 0);

        // Continuous run: R2, R5, R6, R9
        last0 = -1; hi0 = 0; zc = 0; hc = 0; last1 = -1; hi1 = 0;
        pl = int'(lvl[LW-1:0]);
        for (int i = 0; i < 720; i++) begin
            p0 = sq[0]; p1 = sq[1];
            drive(1'b0, 1'b1);
            l = int'(lvl[LW-1:0]);
            check_eq("R5 step size", int'((l - pl) <= 1 && (pl - l) <= 1), 1);
            check_eq("R5 range", int'(l <= H), 1);
            pl = l;
            if (!p0 && sq[0]) begin
                if (last0 >= 0) begin
                    check_eq("R2 period", i - last0, N);
                    check_eq("R2 high time", hi0, H);
                    check_eq("R6 zero hits", zc, 1);
                    check_eq("R6 peak hits", hc, 1);
                end
                last0 = i; hi0 = 0; zc = 0; hc = 0;
            end
            if (sq[0]) hi0++;
            if (l == 0) zc++;
            if (l == H) hc++;
            if (!p1 && sq[1]) begin
                if (last1 >= 0) begin
                    check_eq("R9 period", i - last1, N * N);
                    check_eq("R9 high time", hi1, N * H);
                end
                last1 = i; hi1 = 0;
            end
            if (sq[1]) hi1++;
        end
        check_eq("R9 rises seen", int'(last1 >= 0), 1);

        // Irregular enable: R7 plus scoreboard
        for (int i = 0; i < 300; i++) begin
            logic e;
            logic [S*H-1:0] pt;
            logic [S-1:0] ps;
            e = ((i % 7) != 3) && ((i % 5) != 1);
            pt = taps; ps = sq;
            drive(1'b0, e);
            if (!e) begin
                check_eq("R7 taps frozen", int'(taps), int'(pt));
                check_eq("R7 squares frozen", int'(sq), int'(ps));
            end
        end

        // R10: hold a pending cascade step across enable-low clocks
        begin
            bit hit = 0;
            for (int i = 0; i < 60 && !hit; i++) begin
                p0 = sq[0];
                drive(1'b0, 1'b1);
                if (!p0 && sq[0]) hit = 1;
            end
            check_eq("R10 rise found", int'(hit), 1);
            t1 = taps[N-1:H]; s1 = sq[1];
            repeat (3) drive(1'b0, 1'b0);
            check_eq("R10 held taps", int'(taps[N-1:H]), int'(t1));
            drive(1'b0, 1'b1);
            check_eq("R10 step taken", int'(taps[N-1:H]), int'({t1[H-2:0], s1}));
        end

        // R8: reset while enabled
        repeat (25) drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        check_eq("R8 squares", int'(sq), 3);
        check_eq("R8 taps", int'(taps), 0);
        check_eq("R8 levels", int'(lvl), 0);
        repeat (40) drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        @(negedge clk); #1;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule